// File: doc/BRIEF.md
# UART Interrupt Identification Unit

This block holds the interrupt enable register of a 16550-style serial port and turns four pending conditions into the identification byte and one interrupt line. The four conditions are a line status error, received data being ready, the transmit holding register becoming empty, and a modem status change. Software reads the identification byte to learn which source needs service. The block reports only one source at a time: the highest-priority source that is both enabled and pending.

The serial engine, the FIFOs and the bus decoder stay outside this block. They reach it through four inputs:

- one-cycle event pulses for the line status, transmit-empty and modem sources;
- a level for received data;
- one-cycle read strobes for the identification, line status and modem status registers;
- a write strobe for the transmit holding register.

Each source is cleared by the strobe that belongs to it. The transmit-empty source is also cleared by reading the identification byte, but only while that source is the one being reported. When the FIFOs are enabled, the two top bits of the identification byte read as ones.

Top module: `uart_irq_ident`

## Requirements
- R1: After a synchronous reset the identification byte is 0x01, `irq` is low and the enable readback is 0x00. The transmit-empty condition comes out of reset pending, so writing 0x02 to the enable register then yields 0x02.
- R2: A write strobe stores all 8 bits of `ier_wdata`, and `ier_rdata` returns them from the next cycle on.
- R3: Bits 3:0 of the identification byte carry the code of the reported source: 0x6 for line status, 0x4 for received data, 0x2 for transmit empty and 0x0 for modem status. Priority runs in that same order, highest first.
- R4: A source is reported only while its enable bit is set. Enable bit 0 covers received data, bit 1 transmit empty, bit 2 line status and bit 3 modem status. With nothing enabled and pending, bits 3:0 read 0x1.
- R5: Bits 7:6 of the identification byte are 11 while `fifo_en` is high and 00 otherwise. Bits 5:4 are always 0.
- R6: `irq` is always the inverse of identification bit 0.
- R7: A read of the identification byte clears the transmit-empty condition if transmit empty is the reported source at that read. A read while another source is reported leaves the condition pending.
- R8: A write to the transmit holding register clears the transmit-empty condition.
- R9: A transmit-empty event re-arms the condition after it has been cleared. When an event and a clear arrive in the same cycle, the condition stays pending.
- R10: A line status event latches its condition until the line status register is read. An event in the same cycle as that read keeps the condition pending.
- R11: A modem status event latches its condition until the modem status register is read. An event in the same cycle as that read keeps the condition pending.
- R12: A condition that is latched while its enable bit is clear is kept, and it is reported as soon as the bit is set.
- R13: Received data is not latched. Its code appears and disappears with `rx_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ier_wr | input | 1 | Enable register write strobe |
| ier_wdata | input | 8 | Enable register write data |
| fifo_en | input | 1 | FIFO mode is active |
| ls_evt | input | 1 | Line status error event pulse |
| rx_ready | input | 1 | Received data available or trigger level reached (level) |
| thre_evt | input | 1 | Transmit holding register became empty (pulse) |
| ms_evt | input | 1 | Modem status change event pulse |
| rd_iir | input | 1 | Identification register read strobe |
| rd_lsr | input | 1 | Line status register read strobe |
| rd_msr | input | 1 | Modem status register read strobe |
| wr_thr | input | 1 | Transmit holding register write strobe |
| ier_rdata | output | 8 | Enable register readback |
| iir | output | 8 | Identification byte |
| irq | output | 1 | Interrupt request, active high |

## Verification
The bench reads the identification byte while received data outranks a pending transmit-empty condition. A design that cleared on any identification read would lose the transmit interrupt there. It fires events in the same cycle as their clearing strobes; a design with clear-wins ordering would drop a fresh event. It latches line status while that source is disabled, then enables it; a design that masked at the latch input would never report it. Long random runs also exercise every overlap of the four sources against the priority order and the FIFO-mode bits.

// File: rtl/uirq_pkg.sv
package uirq_pkg;

    localparam int REG_W = 8;
    localparam int NSRC  = 4;
    localparam int SRC_W = $clog2(NSRC);

    // Source index equals priority rank: 0 is served first.
    typedef enum logic [SRC_W-1:0] {
        SRC_LINE = 2'd0,
        SRC_RXD  = 2'd1,
        SRC_TXE  = 2'd2,
        SRC_MDM  = 2'd3
    } src_e;

    // Enable register bit that gates each source, indexed by src_e.
    localparam logic [NSRC-1:0][1:0] EN_POS = {2'd3, 2'd1, 2'd0, 2'd2};

    typedef struct packed {
        logic valid;
        src_e src;
    } sel_t;

    function automatic logic [2:0] src_code(src_e s);
        case (s)
            SRC_LINE: src_code = 3'b011;
            SRC_RXD:  src_code = 3'b010;
            SRC_TXE:  src_code = 3'b001;
            default:  src_code = 3'b000;
        endcase
    endfunction

    function automatic sel_t pick_first(logic [NSRC-1:0] act);
        sel_t s;
        s.valid = 1'b0;
        s.src   = SRC_LINE;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (act[i]) begin
                s.valid = 1'b1;
                s.src   = src_e'(i[SRC_W-1:0]);
            end
        end
        return s;
    endfunction

    function automatic logic [REG_W-1:0] pack_ident(logic fifo, sel_t s);
        logic [REG_W-1:0] v;
        v      = '0;
        v[7:6] = {2{fifo}};
        v[3:1] = s.valid ? src_code(s.src) : 3'b000;
        v[0]   = ~s.valid;
        return v;
    endfunction

endpackage

// File: rtl/uirq_enable_reg.sv
module uirq_enable_reg #(
    parameter int W = uirq_pkg::REG_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)     q <= '0;
        else if (wr) q <= wdata;
    end
endmodule

// File: rtl/uirq_pend_latch.sv
module uirq_pend_latch #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic q
);
    // A fresh event outranks a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (rst)      q <= RST_VAL;
        else if (set) q <= 1'b1;
        else if (clr) q <= 1'b0;
    end
endmodule

// File: rtl/uirq_prio_enc.sv
module uirq_prio_enc
    import uirq_pkg::*;
#(
    parameter int N  = NSRC,
    parameter int EW = REG_W
) (
    input  logic [N-1:0]  pend,
    input  logic [EW-1:0] en_reg,
    input  logic          fifo_en,
    output sel_t          sel,
    output logic [EW-1:0] ident
);
    logic [N-1:0] act;

    for (genvar g = 0; g < N; g++) begin : g_gate
        assign act[g] = pend[g] & en_reg[EN_POS[g]];
    end

    assign sel   = pick_first(act);
    assign ident = pack_ident(fifo_en, sel);
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uirq_pkg::*;
#(
    parameter int DW = REG_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ier_wr,
    input  logic [DW-1:0] ier_wdata,
    input  logic          fifo_en,
    input  logic          ls_evt,
    input  logic          rx_ready,
    input  logic          thre_evt,
    input  logic          ms_evt,
    input  logic          rd_iir,
    input  logic          rd_lsr,
    input  logic          rd_msr,
    input  logic          wr_thr,
    output logic [DW-1:0] ier_rdata,
    output logic [DW-1:0] iir,
    output logic          irq
);
    logic [NSRC-1:0] pend;
    sel_t            sel;
    logic            txe_clr;
    logic            ls_q, txe_q, ms_q;

    uirq_enable_reg #(.W(DW)) u_ier (
        .clk(clk), .rst(rst), .wr(ier_wr), .wdata(ier_wdata), .q(ier_rdata)
    );

    uirq_pend_latch #(.RST_VAL(1'b0)) u_ls (
        .clk(clk), .rst(rst), .set(ls_evt), .clr(rd_lsr), .q(ls_q)
    );

    // The holding register is empty out of reset.
    uirq_pend_latch #(.RST_VAL(1'b1)) u_txe (
        .clk(clk), .rst(rst), .set(thre_evt), .clr(txe_clr), .q(txe_q)
    );

    uirq_pend_latch #(.RST_VAL(1'b0)) u_ms (
        .clk(clk), .rst(rst), .set(ms_evt), .clr(rd_msr), .q(ms_q)
    );

    always_comb begin
        pend           = '0;
        pend[SRC_LINE] = ls_q;
        pend[SRC_RXD]  = rx_ready;
        pend[SRC_TXE]  = txe_q;
        pend[SRC_MDM]  = ms_q;
    end

    uirq_prio_enc #(.N(NSRC), .EW(DW)) u_enc (
        .pend(pend), .en_reg(ier_rdata), .fifo_en(fifo_en),
        .sel(sel), .ident(iir)
    );

    // Identification read cancels transmit-empty only when it is the one shown.
    assign txe_clr = wr_thr | (rd_iir & sel.valid & (sel.src == SRC_TXE));
    assign irq     = sel.valid;
endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk #(
    parameter int DW = uirq_pkg::REG_W
) (
    input logic          clk,
    input logic          rst,
    input logic          ier_wr,
    input logic [DW-1:0] ier_wdata,
    input logic          fifo_en,
    input logic          ls_evt,
    input logic          rx_ready,
    input logic          thre_evt,
    input logic          ms_evt,
    input logic          rd_iir,
    input logic          rd_lsr,
    input logic          rd_msr,
    input logic          wr_thr,
    input logic [DW-1:0] ier_rdata,
    input logic [DW-1:0] iir,
    input logic          irq
);
    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (iir[3:0] == 4'h1 && ier_rdata == '0));

    assert_ier_store_R2: assert property (@(posedge clk) disable iff (rst)
        ier_wr |=> ier_rdata == $past(ier_wdata));

    assert_line_top_R3: assert property (@(posedge clk) disable iff (rst)
        (ls_evt && !ier_wr && ier_rdata[2]) |=> iir[3:0] == 4'h6);

    assert_fifo_bits_R5: assert property (@(posedge clk) disable iff (rst)
        iir[7:4] == {fifo_en, fifo_en, 2'b00});

    assert_irq_inv_R6: assert property (@(posedge clk) disable iff (rst)
        irq == !iir[0]);

    assert_iir_read_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_iir && iir[3:0] == 4'h2 && !thre_evt) |=> iir[3:0] != 4'h2);

    assert_thr_write_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_thr && !thre_evt) |=> iir[3:0] != 4'h2);

    assert_lsr_read_R10: assert property (@(posedge clk) disable iff (rst)
        (rd_lsr && !ls_evt) |=> iir[3:0] != 4'h6);

    assert_msr_read_R11: assert property (@(posedge clk) disable iff (rst)
        (rd_msr && !ms_evt) |=> iir[3:0] != 4'h0);
endmodule

bind uart_irq_ident uart_irq_ident_chk #(.DW(DW)) u_chk (.*);

// File: tb/uart_irq_ident_test.sv
module uart_irq_ident_test;
    localparam int CLK_PERIOD = 10;
    localparam int N_RANDOM   = 4000;

    logic       clk = 1'b0;
    logic       rst, ier_wr, fifo_en, ls_evt, rx_ready, thre_evt, ms_evt;
    logic       rd_iir, rd_lsr, rd_msr, wr_thr, irq;
    logic [7:0] ier_wdata, ier_rdata, iir;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Bench model of the state.
    logic [7:0] m_ier;
    logic       m_ls, m_txe, m_ms;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_irq_ident uut (
        .clk(clk), .rst(rst), .ier_wr(ier_wr), .ier_wdata(ier_wdata),
        .fifo_en(fifo_en), .ls_evt(ls_evt), .rx_ready(rx_ready),
        .thre_evt(thre_evt), .ms_evt(ms_evt), .rd_iir(rd_iir),
        .rd_lsr(rd_lsr), .rd_msr(rd_msr), .wr_thr(wr_thr),
        .ier_rdata(ier_rdata), .iir(iir), .irq(irq)
    );

    function automatic logic [7:0] exp_iir(logic [7:0] en, logic ls, logic rx,
                                           logic tx, logic ms, logic ff);
        logic [7:0] v;
        if (ls && en[2])      v = 8'h06;
        else if (rx && en[0]) v = 8'h04;
        else if (tx && en[1]) v = 8'h02;
        else if (ms && en[3]) v = 8'h00;
        else                  v = 8'h01;
        return v | (ff ? 8'hC0 : 8'h00);
    endfunction

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic clear_strobes();
        ier_wr = 0; ls_evt = 0; thre_evt = 0; ms_evt = 0;
        rd_iir = 0; rd_lsr = 0; rd_msr = 0; wr_thr = 0;
    endtask

    // One clock: advance the model with the inputs set now, then compare.
    task automatic tick();
        logic [7:0] cur;
        logic       txe_clr;
        cur     = exp_iir(m_ier, m_ls, rx_ready, m_txe, m_ms, fifo_en);
        txe_clr = wr_thr || (rd_iir && cur[3:0] == 4'h2);
        @(posedge clk);
        if (rst) begin
            m_ier = 8'h00; m_ls = 0; m_txe = 1; m_ms = 0;
        end else begin
            if (ier_wr) m_ier = ier_wdata;
            m_ls  = ls_evt   ? 1'b1 : (rd_lsr  ? 1'b0 : m_ls);
            m_txe = thre_evt ? 1'b1 : (txe_clr ? 1'b0 : m_txe);
            m_ms  = ms_evt   ? 1'b1 : (rd_msr  ? 1'b0 : m_ms);
        end
        #1;
        clear_strobes();
        #1;
        if (!rst) begin
            cur = exp_iir(m_ier, m_ls, rx_ready, m_txe, m_ms, fifo_en);
            chk("R3", {4'h0, iir[3:0]}, {4'h0, cur[3:0]});
            chk("R5", {iir[7:4], 4'h0}, {cur[7:4], 4'h0});
            chk("R6", {7'h0, irq}, {7'h0, ~cur[0]});
            chk("R2", ier_rdata, m_ier);
        end
    endtask

    task automatic set_ier(logic [7:0] v);
        ier_wr = 1; ier_wdata = v;
        tick();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        clear_strobes();
        ier_wdata = 0; fifo_en = 0; rx_ready = 0; rst = 1;
        m_ier = 0; m_ls = 0; m_txe = 1; m_ms = 0;
        repeat (3) tick();
        rst = 0;
        tick();
        // R1: reset state
        chk("R1", iir, 8'h01);
        chk("R1", {7'h0, irq}, 8'h00);
        chk("R1", ier_rdata, 8'h00);
        set_ier(8'h02);
        chk("R1", iir, 8'h02);               // transmit empty pending out of reset
        // R2: all bits stored
        set_ier(8'hA6);
        chk("R2", ier_rdata, 8'hA6);
        // R7: identification read clears transmit empty when reported
        rd_iir = 1; tick();
        chk("R7", iir, 8'h06 & 8'h01 | 8'h01);
        // R9: re-arm, and event beats clear
        thre_evt = 1; tick();
        chk("R9", iir, 8'h02);
        thre_evt = 1; wr_thr = 1; tick();
        chk("R9", iir, 8'h02);
        // R8: transmit write clears
        wr_thr = 1; tick();
        chk("R8", iir, 8'h01);
        // R7 negative: read while received data is reported leaves it pending
        set_ier(8'h0F);
        thre_evt = 1; rx_ready = 1; tick();
        chk("R13", iir, 8'h04);
        rd_iir = 1; tick();
        rx_ready = 0; tick();
        chk("R7", iir, 8'h02);
        wr_thr = 1; tick();
        // R10: line status latched, outranks received data
        rx_ready = 1; ls_evt = 1; tick();
        chk("R10", iir, 8'h06);
        ls_evt = 1; rd_lsr = 1; tick();
        chk("R10", iir, 8'h06);
        rd_lsr = 1; tick();
        chk("R13", iir, 8'h04);
        rx_ready = 0; tick();
        chk("R4", iir, 8'h01);
        // R11: modem status
        ms_evt = 1; tick();
        chk("R11", iir, 8'h00);
        chk("R6", {7'h0, irq}, 8'h01);
        ms_evt = 1; rd_msr = 1; tick();
        chk("R11", iir, 8'h00);
        rd_msr = 1; tick();
        chk("R11", iir, 8'h01);
        // R12: latched while disabled, reported once enabled
        set_ier(8'h00);
        ls_evt = 1; tick();
        chk("R4", iir, 8'h01);
        set_ier(8'h04);
        chk("R12", iir, 8'h06);
        rd_lsr = 1; tick();
        // R5: FIFO-mode bits
        fifo_en = 1; tick();
        chk("R5", iir, 8'hC1);
        set_ier(8'h02); thre_evt = 1; tick();
        chk("R5", iir, 8'hC2);
        fifo_en = 0; tick();
        chk("R5", iir, 8'h02);

        // Random mix
        for (int i = 0; i < N_RANDOM; i++) begin
            ier_wr    = ($urandom_range(15) == 0);
            ier_wdata = 8'($urandom);
            ls_evt    = ($urandom_range(7) == 0);
            thre_evt  = ($urandom_range(5) == 0);
            ms_evt    = ($urandom_range(7) == 0);
            rd_iir    = ($urandom_range(3) == 0);
            rd_lsr    = ($urandom_range(5) == 0);
            rd_msr    = ($urandom_range(5) == 0);
            wr_thr    = ($urandom_range(5) == 0);
            if ($urandom_range(7) == 0)  rx_ready = ~rx_ready;
            if ($urandom_range(19) == 0) fifo_en  = ~fifo_en;
            tick();
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule